// File: doc/BRIEF.md
# Sweep Stage Sequencer

This block paces a frequency sweep. A start pulse captures the sweep shape: the index of the last point, the number of stages per point, the sample count and the settling delay. The block then walks every point in order. Each point spends one cycle on configuration. Each stage of a point then runs a settling delay, followed by a sampling window, and ends by flagging new data.

A per-point halt input can park the sweep after a point has been configured. The block waits there, before any settling, until a resume pulse arrives. Status flags report a parked sweep, unread result data, and a sticky overrun that records data lost because it was not collected in time. The point and stage indices and a sampling-enable output let neighbouring logic steer the source and capture samples. After the final stage of the last point, a one-cycle done pulse is raised.

Top module: `sweep_seq`

## Requirements
- R1: After synchronous reset, busy_o, sampling_o, halted_o, newdata_o, overrun_o and done_o are 0, and point_o and stage_o are 0.
- R2: A start_i pulse while idle captures all configuration inputs and sets busy_o. It begins point 0 at stage 0 with one configuration cycle. Every later point also begins with one configuration cycle, in which busy_o is 1 and sampling_o is 0.
- R3: Each stage opens with a settling phase of settle_i+1 clock cycles. sampling_o is 0 during this phase.
- R4: The sampling window keeps sampling_o at 1 until exactly spp_i×16 pulses of smp_tick_i have been seen. A spp_i of 0 is treated as 1. Cycles without a tick extend the window.
- R5: last_stg_i holds the stage count minus one. stage_o runs from 0 to last_stg_i within every point and returns to 0 at the next point.
- R6: newdata_o rises on the edge that ends each stage and falls on the edge after ack_i is seen high. When a stage ends in the same cycle as ack_i, newdata_o stays 1.
- R7: overrun_o is set when a stage ends while newdata_o is still 1 and ack_i is low. Once set, only reset clears it.
- R8: When halt_i is high in a point's configuration cycle, halted_o rises and the sequence waits with sampling_o at 0 and point_o unchanged. A resume_i pulse clears halted_o and starts the settling phase.
- R9: last_pt_i is the index of the last point; values above 4500 are clamped to 4500. After the final stage of the last point, busy_o falls and done_o is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| last_pt_i | input | 13 | Index of last sweep point |
| last_stg_i | input | 3 | Stages per point minus one |
| spp_i | input | 13 | Samples per stage in units of 16 |
| settle_i | input | 16 | Settling delay in clocks (phase lasts value+1) |
| halt_i | input | 1 | Halt request for the point being configured |
| resume_i | input | 1 | Resume pulse for a halted sweep |
| smp_tick_i | input | 1 | Sample-enable pulse from the converter side |
| ack_i | input | 1 | Result data has been read |
| busy_o | output | 1 | Sweep in progress |
| sampling_o | output | 1 | Sampling window open |
| point_o | output | 13 | Current point index |
| stage_o | output | 3 | Current stage index |
| halted_o | output | 1 | Sweep parked awaiting resume |
| newdata_o | output | 1 | Unread result data present |
| overrun_o | output | 1 | Sticky data-loss flag |
| done_o | output | 1 | One-cycle pulse at sweep completion |

## Verification
Two events can land on the same edge: the end of a stage and the acknowledge of the previous result. The bench provokes this by holding ack_i high for a whole sweep, so every stage end meets an acknowledge. It then expects newdata_o to pulse once per stage and overrun_o to stay 0. A separate sweep with no acknowledge at all must set overrun_o at the second stage end. That flag must survive a later acknowledge and a fresh sweep, and clear only on reset.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_HOLD,
    ST_SETTLE,
    ST_SAMPLE
  } seq_state_t;
endpackage

// File: rtl/sweep_timer.sv
module sweep_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sweep_flags.sv
module sweep_flags (
  input  logic clk,
  input  logic rst,
  input  logic stage_end_i,
  input  logic ack_i,
  input  logic hold_set_i,
  input  logic hold_clr_i,
  output logic newdata_o,
  output logic overrun_o,
  output logic halted_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      newdata_o <= 1'b0;
      overrun_o <= 1'b0;
      halted_o  <= 1'b0;
    end else begin
      if (stage_end_i)  newdata_o <= 1'b1;
      else if (ack_i)   newdata_o <= 1'b0;
      if (stage_end_i && newdata_o && !ack_i) overrun_o <= 1'b1;
      if (hold_set_i)      halted_o <= 1'b1;
      else if (hold_clr_i) halted_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int MAX_PTS = 4501,
  parameter int PTS_W   = 13,
  parameter int STG_W   = 3,
  parameter int SPP_W   = 13,
  parameter int SET_W   = 16,
  parameter int CNT_W   = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PTS_W-1:0] last_pt_i,
  input  logic [STG_W-1:0] last_stg_i,
  input  logic [SPP_W-1:0] spp_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             halt_i,
  input  logic             resume_i,
  input  logic             smp_tick_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_dec_o,
  output logic             stage_end_o,
  output logic             hold_set_o,
  output logic             hold_clr_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             sampling_o,
  output logic [PTS_W-1:0] point_o,
  output logic [STG_W-1:0] stage_o
);
  localparam logic [PTS_W-1:0] PT_CAP = PTS_W'(MAX_PTS - 1);

  seq_state_t       st_q, st_d;
  logic [PTS_W-1:0] last_pt_q, point_q;
  logic [STG_W-1:0] last_stg_q, stage_q;
  logic [SPP_W-1:0] spp_q, spp_eff;
  logic [SET_W-1:0] settle_q;
  logic [CNT_W-1:0] settle_val, smp_len_m1;
  logic             adv_stage, adv_point, fin;

  assign spp_eff    = (spp_q == '0) ? SPP_W'(1) : spp_q;
  assign smp_len_m1 = CNT_W'({spp_eff, 4'b0000}) - 1'b1;
  assign settle_val = CNT_W'(settle_q);

  always_comb begin
    st_d        = st_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = settle_val;
    tmr_dec_o   = 1'b0;
    stage_end_o = 1'b0;
    hold_set_o  = 1'b0;
    hold_clr_o  = 1'b0;
    adv_stage   = 1'b0;
    adv_point   = 1'b0;
    fin         = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CFG;
      ST_CFG: begin
        if (halt_i) begin
          st_d       = ST_HOLD;
          hold_set_o = 1'b1;
        end else begin
          st_d       = ST_SETTLE;
          tmr_load_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (resume_i) begin
          st_d       = ST_SETTLE;
          tmr_load_o = 1'b1;
          hold_clr_o = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          st_d       = ST_SAMPLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = smp_len_m1;
        end else begin
          tmr_dec_o = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (smp_tick_i) begin
          if (tmr_zero_i) begin
            stage_end_o = 1'b1;
            if (stage_q == last_stg_q) begin
              if (point_q == last_pt_q) begin
                st_d = ST_IDLE;
                fin  = 1'b1;
              end else begin
                st_d      = ST_CFG;
                adv_point = 1'b1;
              end
            end else begin
              st_d       = ST_SETTLE;
              tmr_load_o = 1'b1;
              adv_stage  = 1'b1;
            end
          end else begin
            tmr_dec_o = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      last_pt_q  <= '0;
      last_stg_q <= '0;
      spp_q      <= '0;
      settle_q   <= '0;
      point_q    <= '0;
      stage_q    <= '0;
      done_o     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin;
      if (st_q == ST_IDLE && start_i) begin
        last_pt_q  <= (last_pt_i > PT_CAP) ? PT_CAP : last_pt_i;
        last_stg_q <= last_stg_i;
        spp_q      <= spp_i;
        settle_q   <= settle_i;
        point_q    <= '0;
        stage_q    <= '0;
      end else if (adv_point) begin
        point_q <= point_q + 1'b1;
        stage_q <= '0;
      end else if (adv_stage) begin
        stage_q <= stage_q + 1'b1;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign sampling_o = (st_q == ST_SAMPLE);
  assign point_o    = point_q;
  assign stage_o    = stage_q;
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq #(
  parameter int MAX_PTS = 4501,
  parameter int STG_W   = 3,
  parameter int SPP_W   = 13,
  parameter int SET_W   = 16,
  localparam int PTS_W  = $clog2(MAX_PTS),
  localparam int CNT_W  = (SET_W > SPP_W + 4) ? SET_W : SPP_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PTS_W-1:0] last_pt_i,
  input  logic [STG_W-1:0] last_stg_i,
  input  logic [SPP_W-1:0] spp_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             halt_i,
  input  logic             resume_i,
  input  logic             smp_tick_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             sampling_o,
  output logic [PTS_W-1:0] point_o,
  output logic [STG_W-1:0] stage_o,
  output logic             halted_o,
  output logic             newdata_o,
  output logic             overrun_o,
  output logic             done_o
);
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             stage_end, hold_set, hold_clr;

  sweep_ctrl #(
    .MAX_PTS(MAX_PTS), .PTS_W(PTS_W), .STG_W(STG_W),
    .SPP_W(SPP_W), .SET_W(SET_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .last_pt_i(last_pt_i),
    .last_stg_i(last_stg_i), .spp_i(spp_i), .settle_i(settle_i),
    .halt_i(halt_i), .resume_i(resume_i), .smp_tick_i(smp_tick_i),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .tmr_dec_o(tmr_dec), .stage_end_o(stage_end), .hold_set_o(hold_set),
    .hold_clr_o(hold_clr), .done_o(done_o), .busy_o(busy_o),
    .sampling_o(sampling_o), .point_o(point_o), .stage_o(stage_o)
  );

  sweep_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  sweep_flags u_flags (
    .clk(clk), .rst(rst), .stage_end_i(stage_end), .ack_i(ack_i),
    .hold_set_i(hold_set), .hold_clr_i(hold_clr), .newdata_o(newdata_o),
    .overrun_o(overrun_o), .halted_o(halted_o)
  );
endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk #(
  parameter int PTS_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             sampling_o,
  input logic             halted_o,
  input logic             overrun_o,
  input logic             done_o,
  input logic             resume_i,
  input logic [PTS_W-1:0] point_o
);
  p_sample_in_sweep_r4: assert property (@(posedge clk) disable iff (rst)
    sampling_o |-> busy_o);

  p_halt_no_sample_r8: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !sampling_o);

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !resume_i) |=> (halted_o && $stable(point_o)));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind sweep_seq sweep_seq_chk #(.PTS_W(PTS_W)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .sampling_o(sampling_o),
  .halted_o(halted_o), .overrun_o(overrun_o), .done_o(done_o),
  .resume_i(resume_i), .point_o(point_o)
);

// File: tb/sweep_seq_test.sv
module sweep_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, halt_i = 1'b0, resume_i = 1'b0;
  logic        smp_tick_i = 1'b1, ack_i = 1'b0;
  logic [12:0] last_pt_i = '0;
  logic [2:0]  last_stg_i = '0;
  logic [12:0] spp_i = '0;
  logic [15:0] settle_i = '0;
  logic        busy_o, sampling_o, halted_o, newdata_o, overrun_o, done_o;
  logic [12:0] point_o;
  logic [2:0]  stage_o;

  int checks = 0, fails = 0, cyc = 0;
  int n_busy, n_smp, n_nd, p_max, s_max, saw_done;

  // last point, last stage, spp, settle, ack mode (1 = ack held high)
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 0, 1, 0, 0},
    '{2, 1, 1, 2, 0},
    '{1, 3, 2, 0, 0},
    '{0, 2, 0, 1, 0},
    '{3, 0, 1, 5, 1},
    '{1, 1, 1, 0, 1}
  };

  always #2.5 clk = ~clk;

  sweep_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .last_pt_i(last_pt_i),
    .last_stg_i(last_stg_i), .spp_i(spp_i), .settle_i(settle_i),
    .halt_i(halt_i), .resume_i(resume_i), .smp_tick_i(smp_tick_i),
    .ack_i(ack_i), .busy_o(busy_o), .sampling_o(sampling_o),
    .point_o(point_o), .stage_o(stage_o), .halted_o(halted_o),
    .newdata_o(newdata_o), .overrun_o(overrun_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // starts a sweep and watches it until done; ack_mode 0 acks each result
  task automatic run_sweep(input int lp, input int ls, input int sp,
                           input int st, input int ack_mode);
    last_pt_i = 13'(lp); last_stg_i = 3'(ls);
    spp_i = 13'(sp); settle_i = 16'(st);
    ack_i = (ack_mode == 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_busy = 0; n_smp = 0; n_nd = 0; p_max = 0; s_max = 0;
    for (int k = 0; k < 100000; k++) begin
      if (done_o) break;
      n_busy += int'(busy_o);
      n_smp  += int'(sampling_o);
      n_nd   += int'(newdata_o);
      if (int'(point_o) > p_max) p_max = int'(point_o);
      if (int'(stage_o) > s_max) s_max = int'(stage_o);
      if (ack_mode == 0) ack_i = newdata_o;
      @(negedge clk);
    end
    saw_done = int'(done_o);
    n_nd += int'(newdata_o);
    if (ack_mode == 0) ack_i = newdata_o;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 flags", {sampling_o, halted_o, newdata_o, overrun_o, done_o}, 0);
    chk("R1 indices", {point_o, stage_o}, 0);

    // R2 first cycle after start: configuration of point 0
    last_pt_i = 13'd0; last_stg_i = 3'd0; spp_i = 13'd1; settle_i = 16'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    chk("R2 cfg no sampling", sampling_o, 0);
    chk("R2 point/stage zero", {point_o, stage_o}, 0);
    repeat (40) @(negedge clk);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;

    // table of sweeps
    for (int v = 0; v < NV; v++) begin
      int lp, ls, sp, st, spe, exp_busy;
      lp = VEC[v][0]; ls = VEC[v][1]; sp = VEC[v][2]; st = VEC[v][3];
      spe = (sp == 0) ? 1 : sp;
      exp_busy = (lp + 1) * (1 + (ls + 1) * (st + 1 + 16 * spe));
      run_sweep(lp, ls, sp, st, VEC[v][4]);
      chk("R2 R3 busy cycles", n_busy, exp_busy);
      chk("R4 sampling cycles", n_smp, (lp + 1) * (ls + 1) * 16 * spe);
      chk("R6 new data per stage", n_nd, (lp + 1) * (ls + 1));
      chk("R5 last stage index", s_max, ls);
      chk("R9 last point index", p_max, lp);
      chk("R9 done seen", saw_done, 1);
      chk("R9 done one cycle", done_o, 0);
      chk("R9 idle after done", busy_o, 0);
      chk("R6 R7 no overrun", overrun_o, 0);
    end

    // R8 halt on point 0 with settle 3, point 1 not halted
    last_pt_i = 13'd1; last_stg_i = 3'd0; spp_i = 13'd1; settle_i = 16'd3;
    halt_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    halt_i = 1'b0;
    chk("R8 halted set", halted_o, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 6; k++) begin
        if (sampling_o || !halted_o || point_o != 0) bad++;
        @(negedge clk);
      end
      chk("R8 parked while halted", bad, 0);
    end
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
    chk("R8 halted cleared", halted_o, 0);
    begin
      int d = 0;
      while (!sampling_o && d < 100) begin d++; @(negedge clk); end
      chk("R3 settle after resume", d, 4);
    end
    begin
      int hseen = 0;
      for (int k = 0; k < 200 && !done_o; k++) begin
        hseen += int'(halted_o);
        ack_i = newdata_o;
        @(negedge clk);
      end
      chk("R8 second point not halted", hseen, 0);
      chk("R9 halted sweep completes", done_o, 1);
    end
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;

    // R4 ticks gate the sampling window
    smp_tick_i = 1'b0;
    last_pt_i = 13'd0; last_stg_i = 3'd0; spp_i = 13'd1; settle_i = 16'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    begin
      int held = 0;
      for (int k = 0; k < 10; k++) begin
        held += int'(sampling_o);
        @(negedge clk);
      end
      chk("R4 window waits for ticks", held, 10);
    end
    smp_tick_i = 1'b1;
    begin
      int w = 0;
      while (sampling_o && w < 100) begin w++; @(negedge clk); end
      chk("R4 window length in ticks", w, 16);
    end
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;

    // R7 overrun: two stages with no acknowledge
    run_sweep(0, 1, 1, 0, 2);
    chk("R7 overrun set", overrun_o, 1);
    chk("R6 data still pending", newdata_o, 1);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0; @(negedge clk);
    chk("R6 ack clears new data", newdata_o, 0);
    chk("R7 overrun survives ack", overrun_o, 1);
    run_sweep(0, 0, 1, 0, 1);
    chk("R7 overrun survives sweep", overrun_o, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R7 reset clears overrun", overrun_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule